// File: doc/BRIEF.md
# Precision Time-of-Day Counter with Frequency Trim

This block keeps wall-clock time for a network timing unit. A 48-bit seconds count and a 30-bit nanoseconds count advance by a fixed number of nanoseconds on every reference clock. When nanoseconds reach one billion they roll over to zero and seconds increment. Software reaches the counter through a small command port. It writes a pair of shadow registers and issues one of four action codes. One action copies the running time into the shadows in a single clock. One copies the shadows into the counter. One adds the signed shadow nanoseconds to the counter. The fourth does nothing.

A frequency trim compensates for drift of the reference oscillator. Software programs an interval, a unit bit, a direction bit and an enable bit. A picosecond accumulator then advances by the clock period on every cycle. Each time the programmed interval elapses, the counter gains or loses one nanosecond in that tick. A step that leaves nanoseconds a few counts below zero is kept in a small negative window rather than borrowed. Software that reads such a value treats it as one second fewer plus (low four bits + 999,999,984) ns.

Top module: `ptp_tod_core`

## Requirements
- R1: While reset is low, the live time, the shadow registers and the trim enable are all zero.
- R2: Each clock without a command adds NS_INC (default 5) to nanoseconds. A sum reaching 1,000,000,000 subtracts that amount and increments the 48-bit seconds, which wrap from all ones to zero.
- R3: Action code 2 (LOAD) makes the live time equal the shadow seconds and nanoseconds in the cycle after the command.
- R4: Action code 1 (SAVE) copies into the shadows the seconds and nanoseconds shown on the live outputs during the command cycle. Both fields come from that one cycle. The live counter keeps advancing.
- R5: Action code 3 (DELTA) adds the shadow nanoseconds, read as a 30-bit two's-complement number, plus NS_INC to the live nanoseconds. A result at or above one billion carries into seconds in the same cycle.
- R6: A DELTA result below -16 ns borrows: seconds decrease by one and nanoseconds become the result plus 1,000,000,000.
- R7: A result from -16 to -1 ns is stored as 2^30 plus that value (0x3FFFFFF0 to 0x3FFFFFFF) with seconds unchanged. The next ticks continue from the signed value and leave the window normally.
- R8: A trim write sets the interval in picoseconds to the 30-bit value, or to that value times 1000 when the unit bit is 1, and clears the accumulator. While enabled, the number of 1 ns corrections after N clocks is floor(N x CLK_PS / interval). This holds for intervals of at least one clock period. Each correction adds 1 ns with direction 0 and removes 1 ns with direction 1.
- R9: A trim write with enable 0 stops all corrections.
- R10: Action code 0 (IDLE), and a command cycle with no shadow write, leave the shadow registers unchanged.
- R11: A shadow write places the written seconds and nanoseconds on the shadow outputs after the write clock. SAVE takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_action | input | 2 | Action code: 0 idle, 1 save, 2 load, 3 delta |
| shd_wr | input | 1 | Shadow register write strobe |
| shd_wr_sec_lo | input | 32 | Shadow seconds, low word, to write |
| shd_wr_sec_hi | input | 16 | Shadow seconds, high word, to write |
| shd_wr_ns | input | 30 | Shadow nanoseconds to write (signed for delta) |
| trim_wr | input | 1 | Trim configuration write strobe |
| trim_interval | input | 30 | Interval between 1 ns corrections |
| trim_unit_ns | input | 1 | Interval unit: 0 picoseconds, 1 nanoseconds |
| trim_dir | input | 1 | 0 gain a nanosecond, 1 lose a nanosecond |
| trim_en | input | 1 | Trim enable |
| tod_sec_lo | output | 32 | Live seconds, low word |
| tod_sec_hi | output | 16 | Live seconds, high word |
| tod_ns | output | 30 | Live nanoseconds |
| shd_sec_lo | output | 32 | Shadow seconds, low word |
| shd_sec_hi | output | 16 | Shadow seconds, high word |
| shd_ns | output | 30 | Shadow nanoseconds |

## Verification
The bench loads a time just below a second boundary and captures it on the boundary cycle. This distinguishes an atomic capture from a torn one and checks the 48-bit carry. Positive, negative, exactly -16 and -17 ns delta steps separate carry, borrow and the negative window from one another. Trim runs with a picosecond interval that divides the clock period evenly, a nanosecond-unit interval that does not, and a long odd interval. These separate unit scaling, direction and remainder keeping in the accumulator. A disabled run confirms pure nominal advance.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int SEC_W    = 48;
  localparam int SEC_LO_W = 32;
  localparam int SEC_HI_W = SEC_W - SEC_LO_W;
  localparam int NS_W     = 30;
  localparam int ACC_W    = NS_W + 11;

  localparam logic signed [31:0] NS_PER_SEC_S = 32'sd1000000000;
  localparam logic signed [31:0] NEG_WIN_S    = 32'sd16;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_SAVE  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_DELTA = 2'd3
  } tod_action_e;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } tod_t;

  // Interpret a stored nanoseconds field, honouring the negative window.
  function automatic logic signed [31:0] ns_as_signed(logic [NS_W-1:0] ns);
    if (&ns[NS_W-1:4]) return {{28{1'b1}}, ns[3:0]};
    else               return {{(32-NS_W){1'b0}}, ns};
  endfunction

  // Add a signed nanosecond amount and renormalise.
  function automatic tod_t tod_step(tod_t cur, logic signed [31:0] add);
    logic signed [31:0] s;
    tod_t r;
    s = ns_as_signed(cur.ns) + add;
    r = cur;
    if (s >= NS_PER_SEC_S) begin
      r.ns  = NS_W'(s - NS_PER_SEC_S);
      r.sec = cur.sec + 1'b1;
    end else if (s >= -NEG_WIN_S) begin
      r.ns  = NS_W'(s);
    end else begin
      r.ns  = NS_W'(s + NS_PER_SEC_S);
      r.sec = cur.sec - 1'b1;
    end
    return r;
  endfunction

  function automatic logic [ACC_W-1:0] trim_ps(logic [NS_W-1:0] v, logic unit_ns);
    if (unit_ns) return ACC_W'(v) * ACC_W'(1000);
    else         return ACC_W'(v);
  endfunction
endpackage

// File: rtl/tod_trim.sv
`timescale 1ns/1ps
module tod_trim
  import tod_pkg::*;
#(
  parameter int CLK_PS = 5000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [NS_W-1:0] interval_i,
  input  logic            unit_ns_i,
  input  logic            dir_i,
  input  logic            en_i,
  output logic            fire_o,
  output logic            dir_o
);
  localparam logic [ACC_W-1:0] STEP_PS = ACC_W'(CLK_PS);

  logic             en_q;
  logic             dir_q;
  logic [ACC_W-1:0] intv_ps_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] rem;

  assign sum    = acc_q + STEP_PS;
  assign rem    = sum - intv_ps_q;
  assign fire_o = en_q && (intv_ps_q != '0) && (sum >= intv_ps_q);
  assign dir_o  = dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      dir_q     <= 1'b0;
      intv_ps_q <= '0;
      acc_q     <= '0;
    end else if (wr_i) begin
      en_q      <= en_i;
      dir_q     <= dir_i;
      intv_ps_q <= trim_ps(interval_i, unit_ns_i);
      acc_q     <= '0;
    end else if (!en_q) begin
      acc_q <= '0;
    end else if (fire_o) begin
      acc_q <= (rem >= intv_ps_q) ? '0 : rem;
    end else begin
      acc_q <= sum;
    end
  end

  AST_TRIM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !fire_o) else $error("trim fired while disabled"); // R9
  AST_ACC_BELOW_INTERVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && intv_ps_q >= STEP_PS) |-> (acc_q < intv_ps_q))
    else $error("trim accumulator beyond interval"); // R8
endmodule

// File: rtl/tod_shadow.sv
`timescale 1ns/1ps
module tod_shadow
  import tod_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic save_i,
  input  tod_t live_i,
  input  logic wr_i,
  input  tod_t wr_val_i,
  output tod_t shd_o
);
  tod_t shd_q;
  assign shd_o = shd_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      shd_q <= '0;
    else if (save_i) shd_q <= live_i;
    else if (wr_i)   shd_q <= wr_val_i;
  end

  AST_SAVE_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    save_i |=> (shd_q == $past(live_i))) else $error("capture torn"); // R4
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !save_i) |=> (shd_q == $past(wr_val_i))) else $error("write lost"); // R11
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !save_i) |=> $stable(shd_q)) else $error("shadow changed"); // R10
endmodule

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
module tod_counter
  import tod_pkg::*;
#(
  parameter int NS_INC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  tod_t            load_val_i,
  input  logic            delta_i,
  input  logic [NS_W-1:0] delta_ns_i,
  input  logic            trim_fire_i,
  input  logic            trim_dir_i,
  output tod_t            tod_o
);
  tod_t               tod_q;
  logic signed [31:0] add;

  always_comb begin
    add = 32'(NS_INC);
    if (trim_fire_i) add = add + (trim_dir_i ? -32'sd1 : 32'sd1);
    if (delta_i)     add = add + {{(32-NS_W){delta_ns_i[NS_W-1]}}, delta_ns_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      tod_q <= '0;
    else if (load_i) tod_q <= load_val_i;
    else             tod_q <= tod_step(tod_q, add);
  end

  assign tod_o = tod_q;

  AST_NS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_q.ns < NS_W'(1000000000)) || (&tod_q.ns[NS_W-1:4]))
    else $error("nanoseconds out of range"); // R2
  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (tod_q == $past(load_val_i))) else $error("load mismatch"); // R3
  AST_TICK_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !delta_i) |=> (tod_q.sec == $past(tod_q.sec) ||
                               tod_q.sec == $past(tod_q.sec) + 1'b1))
    else $error("seconds jumped on tick"); // R2
  AST_DELTA_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (delta_i && !load_i) |=> (tod_q.sec == $past(tod_q.sec) ||
                              tod_q.sec == $past(tod_q.sec) + 1'b1 ||
                              tod_q.sec == $past(tod_q.sec) - 1'b1))
    else $error("delta moved seconds too far"); // R5, R6
  AST_WINDOW_KEEPS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !delta_i) |=> (!(&tod_q.ns[NS_W-1:4]) || tod_q.sec == $past(tod_q.sec)))
    else $error("window changed seconds"); // R7
endmodule

// File: rtl/ptp_tod_core.sv
`timescale 1ns/1ps
module ptp_tod_core
  import tod_pkg::*;
#(
  parameter int NS_INC = 5,
  parameter int CLK_PS = 5000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_action,
  input  logic                shd_wr,
  input  logic [SEC_LO_W-1:0] shd_wr_sec_lo,
  input  logic [SEC_HI_W-1:0] shd_wr_sec_hi,
  input  logic [NS_W-1:0]     shd_wr_ns,
  input  logic                trim_wr,
  input  logic [NS_W-1:0]     trim_interval,
  input  logic                trim_unit_ns,
  input  logic                trim_dir,
  input  logic                trim_en,
  output logic [SEC_LO_W-1:0] tod_sec_lo,
  output logic [SEC_HI_W-1:0] tod_sec_hi,
  output logic [NS_W-1:0]     tod_ns,
  output logic [SEC_LO_W-1:0] shd_sec_lo,
  output logic [SEC_HI_W-1:0] shd_sec_hi,
  output logic [NS_W-1:0]     shd_ns
);
  tod_action_e act;
  logic        do_save, do_load, do_delta;
  logic        trim_fire, trim_dir_q;
  tod_t        live, shadow, wr_val;

  assign act      = tod_action_e'(cmd_action);
  assign do_save  = cmd_valid && (act == ACT_SAVE);
  assign do_load  = cmd_valid && (act == ACT_LOAD);
  assign do_delta = cmd_valid && (act == ACT_DELTA);
  assign wr_val   = '{sec: {shd_wr_sec_hi, shd_wr_sec_lo}, ns: shd_wr_ns};

  tod_trim #(.CLK_PS(CLK_PS)) u_trim (
    .clk(clk), .rst_n(rst_n), .wr_i(trim_wr), .interval_i(trim_interval),
    .unit_ns_i(trim_unit_ns), .dir_i(trim_dir), .en_i(trim_en),
    .fire_o(trim_fire), .dir_o(trim_dir_q)
  );

  tod_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .save_i(do_save), .live_i(live),
    .wr_i(shd_wr), .wr_val_i(wr_val), .shd_o(shadow)
  );

  tod_counter #(.NS_INC(NS_INC)) u_counter (
    .clk(clk), .rst_n(rst_n), .load_i(do_load), .load_val_i(shadow),
    .delta_i(do_delta), .delta_ns_i(shadow.ns), .trim_fire_i(trim_fire),
    .trim_dir_i(trim_dir_q), .tod_o(live)
  );

  assign tod_sec_lo = live.sec[SEC_LO_W-1:0];
  assign tod_sec_hi = live.sec[SEC_W-1:SEC_LO_W];
  assign tod_ns     = live.ns;
  assign shd_sec_lo = shadow.sec[SEC_LO_W-1:0];
  assign shd_sec_hi = shadow.sec[SEC_W-1:SEC_LO_W];
  assign shd_ns     = shadow.ns;
endmodule

// File: tb/test_ptp_tod_core.sv
`timescale 1ns/1ps
module test_ptp_tod_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_action = 2'd0;
  logic        shd_wr = 1'b0;
  logic [31:0] shd_wr_sec_lo = '0;
  logic [15:0] shd_wr_sec_hi = '0;
  logic [29:0] shd_wr_ns = '0;
  logic        trim_wr = 1'b0;
  logic [29:0] trim_interval = '0;
  logic        trim_unit_ns = 1'b0;
  logic        trim_dir = 1'b0;
  logic        trim_en = 1'b0;
  logic [31:0] tod_sec_lo, shd_sec_lo;
  logic [15:0] tod_sec_hi, shd_sec_hi;
  logic [29:0] tod_ns, shd_ns;

  always #2.5 clk = ~clk;

  ptp_tod_core i_ptp_tod_core (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_action(cmd_action),
    .shd_wr(shd_wr), .shd_wr_sec_lo(shd_wr_sec_lo), .shd_wr_sec_hi(shd_wr_sec_hi),
    .shd_wr_ns(shd_wr_ns), .trim_wr(trim_wr), .trim_interval(trim_interval),
    .trim_unit_ns(trim_unit_ns), .trim_dir(trim_dir), .trim_en(trim_en),
    .tod_sec_lo(tod_sec_lo), .tod_sec_hi(tod_sec_hi), .tod_ns(tod_ns),
    .shd_sec_lo(shd_sec_lo), .shd_sec_hi(shd_sec_hi), .shd_ns(shd_ns)
  );

  typedef struct {
    string       rid;
    bit          shadow;
    logic [47:0] sec;
    logic [29:0] ns;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;

  // Monitor: compares queued expectations mid-cycle.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      logic [47:0] a_sec;
      logic [29:0] a_ns;
      e = sb.pop_front();
      a_sec = e.shadow ? {shd_sec_hi, shd_sec_lo} : {tod_sec_hi, tod_sec_lo};
      a_ns  = e.shadow ? shd_ns : tod_ns;
      n_checks++;
      if (a_sec !== e.sec || a_ns !== e.ns) begin
        n_fails++;
        $display("FAIL %s %s: actual %0d s %0d ns, expected %0d s %0d ns",
                 e.rid, e.shadow ? "shadow" : "live", a_sec, a_ns, e.sec, e.ns);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_tod(string rid, logic [47:0] s, logic [29:0] n);
    exp_t e;
    e.rid = rid; e.shadow = 1'b0; e.sec = s; e.ns = n;
    sb.push_back(e);
  endtask

  task automatic expect_shd(string rid, logic [47:0] s, logic [29:0] n);
    exp_t e;
    e.rid = rid; e.shadow = 1'b1; e.sec = s; e.ns = n;
    sb.push_back(e);
  endtask

  task automatic wr_shadow(logic [47:0] s, logic [29:0] n);
    shd_wr = 1'b1; {shd_wr_sec_hi, shd_wr_sec_lo} = s; shd_wr_ns = n;
    step();
    shd_wr = 1'b0;
  endtask

  task automatic act(logic [1:0] a);
    cmd_valid = 1'b1; cmd_action = a;
    step();
    cmd_valid = 1'b0; cmd_action = 2'd0;
  endtask

  task automatic load_with_trim(logic [29:0] iv, logic un, logic dr, logic en);
    trim_wr = 1'b1; trim_interval = iv; trim_unit_ns = un; trim_dir = dr; trim_en = en;
    cmd_valid = 1'b1; cmd_action = 2'd2;
    step();
    trim_wr = 1'b0; cmd_valid = 1'b0; cmd_action = 2'd0;
  endtask

  localparam logic [47:0] S0 = 48'h1234_5678_9ABC;

  initial begin
    repeat (3) step();
    expect_tod("R1", 48'd0, 30'd0);
    expect_shd("R1", 48'd0, 30'd0);
    rst_n = 1'b1;
    step(); expect_tod("R2", 48'd0, 30'd5);
    step(); expect_tod("R2", 48'd0, 30'd10);

    // load just below a second, then capture on the boundary cycle
    wr_shadow(S0, 30'd999999990);
    expect_shd("R11", S0, 30'd999999990);
    act(2'd2); expect_tod("R3", S0, 30'd999999990);
    step();    expect_tod("R2", S0, 30'd999999995);
    act(2'd1); expect_tod("R2", S0 + 48'd1, 30'd0);
               expect_shd("R4", S0, 30'd999999995);
    step();    expect_tod("R4", S0 + 48'd1, 30'd5);
    act(2'd0); expect_tod("R10", S0 + 48'd1, 30'd10);
               expect_shd("R10", S0, 30'd999999995);

    // 48-bit seconds wrap
    wr_shadow(48'hFFFF_FFFF_FFFF, 30'd999999995);
    act(2'd2); expect_tod("R3", 48'hFFFF_FFFF_FFFF, 30'd999999995);
    step();    expect_tod("R2", 48'd0, 30'd0);

    // positive delta with carry
    wr_shadow(48'd10, 30'd999999000);
    act(2'd2);
    wr_shadow(48'd0, 30'd2000);
    act(2'd3); expect_tod("R5", 48'd11, 30'd1010);

    // negative delta with borrow
    wr_shadow(48'd0, 30'(-3000));
    act(2'd3); expect_tod("R6", 48'd10, 30'd999998020);

    // small negative result held in the window
    wr_shadow(48'd20, 30'd8);
    act(2'd2); expect_tod("R3", 48'd20, 30'd8);
    wr_shadow(48'd0, 30'(-20));
    act(2'd3); expect_tod("R7", 48'd20, 30'h3FFF_FFFE);
    step();    expect_tod("R7", 48'd20, 30'd3);

    // exactly -16 stays in the window and walks out
    wr_shadow(48'd30, 30'd100);
    act(2'd2);
    wr_shadow(48'd0, 30'(-126));
    act(2'd3); expect_tod("R7", 48'd30, 30'h3FFF_FFF0);
    step();    expect_tod("R7", 48'd30, 30'h3FFF_FFF5);
    step();    expect_tod("R7", 48'd30, 30'h3FFF_FFFA);
    step();    expect_tod("R7", 48'd30, 30'h3FFF_FFFF);
    step();    expect_tod("R7", 48'd30, 30'd4);

    // -17 borrows instead
    wr_shadow(48'd40, 30'd100);
    act(2'd2);
    wr_shadow(48'd0, 30'(-127));
    act(2'd3); expect_tod("R6", 48'd39, 30'd999999983);

    // trim: 100000 ps, gain
    wr_shadow(48'd50, 30'd0);
    load_with_trim(30'd100000, 1'b0, 1'b0, 1'b1);
    expect_tod("R8", 48'd50, 30'd0);
    repeat (400) step();
    expect_tod("R8", 48'd50, 30'd2020);

    // trim: 7 ns unit, lose
    wr_shadow(48'd60, 30'd0);
    load_with_trim(30'd7, 1'b1, 1'b1, 1'b1);
    repeat (700) step();
    expect_tod("R8", 48'd60, 30'd3000);

    // trim: odd long interval keeps its remainder
    wr_shadow(48'd70, 30'd0);
    load_with_trim(30'd333333, 1'b0, 1'b0, 1'b1);
    repeat (10000) step();
    expect_tod("R8", 48'd70, 30'd50150);

    // trim disabled
    wr_shadow(48'd80, 30'd0);
    load_with_trim(30'd100000, 1'b0, 1'b0, 1'b0);
    repeat (400) step();
    expect_tod("R9", 48'd80, 30'd2000);

    step(); step();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule